// File: doc/BRIEF.md
# Decoded I/O Bus Interface with Wait-State Handshake

This block connects a simple processor bus to four input sources and four output destinations. A two-bit address picks one device from each group. A qualifier line tells I/O cycles apart from memory cycles. A read puts the chosen source's held word on the read-data output and raises a drive-enable. A write captures the bus word into the chosen destination latch. Memory cycles leave every device untouched, so a memory and an I/O device can never drive the bus together.

Each source keeps a one-word holding register and a flag that shows whether it holds data. A load pulse from the device fills the register. A completed read empties it. Each destination reports a ready level. When the addressed device cannot take part yet, the block raises a wait output, and the processor holds its address, strobe and data until wait falls. A transfer completes on the first clock edge at which the request is present and wait is low.

A small cycle state machine has four states: `ST_IDLE`, `ST_RD_STALL`, `ST_WR_STALL` and `ST_RECOVER`. Its transitions are:
- idle to read-stall, on a read of an empty source;
- idle to write-stall, on a write to a destination that is not ready;
- idle, read-stall or write-stall to recover, when a transfer completes;
- read-stall or write-stall back to idle, when the request is withdrawn;
- recover to idle, once both strobes are low at an edge.

Recover makes sure that one strobe gives exactly one transfer.

Top module: `iobus_port_ctrl`

## Requirements
- R1: After reset, wait, drive-enable, read data, every destination strobe and every destination latch are zero, and every source is empty.
- R2: Address value k (0 to 3) selects source k for reads and destination k for writes. A read presents that source's held word on `io_rdata` with `io_drive` high in the same cycle. Destination k sits at bits `[8k+7:8k]` of `dst_q` and `src_data`.
- R3: While `io_iom` is low, no device is selected: drive-enable, wait and strobes stay low, no latch changes and no source is emptied.
- R4: A cycle with `io_rd` and `io_wr` both high is treated as no access, with the same effects as R3.
- R5: A read of an empty source raises `io_wait` in the same cycle. A high `src_load[k]` at a clock edge captures the slice of `src_data` for source k and marks it full, and wait drops in the cycle that follows that edge.
- R6: A write raises `io_wait` for as long as `dst_ready` of the addressed destination is low. The latch does not change while wait is high.
- R7: A write completes on the first edge with wait low. `dst_strobe[k]` is high during that cycle, `dst_q` slice k takes `io_wdata` at that edge, and the slice holds its value until the next write to k.
- R8: A completed read empties its source, so the next read of it waits. A load at the same edge as the consuming read wins: the source stays full and holds the new word.
- R9: After a completed transfer, drive-enable, wait and strobes stay low while the processor still holds its strobe. No further transfer happens until `io_rd` and `io_wr` have both been low at one edge.
- R10: Withdrawing the request during a stall returns the block to idle with no transfer and no change to any latch or source.
- R11: Whenever `io_drive` is low, `io_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 2 | Device address |
| io_iom | input | 1 | High for I/O cycles, low for memory cycles |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data from the processor |
| io_rdata | output | 8 | Read data, zero when not driving |
| io_drive | output | 1 | Drive-enable for the read data |
| io_wait | output | 1 | Stretch the current cycle |
| src_load | input | 4 | Per-source load pulse |
| src_data | input | 32 | Per-source data words, packed |
| dst_ready | input | 4 | Per-destination ready level |
| dst_strobe | output | 4 | Per-destination latch strobe |
| dst_q | output | 32 | Destination latch contents, packed |

## Verification
Wait, drive-enable, read data and strobes are combinational from the request, so the bench checks them one nanosecond after it drives inputs on the falling edge, within the same cycle. Latch contents, source emptying, loads and the return from recover each take effect at the next rising edge, so they are checked just after the following falling edge. Stalls of random length stretch accesses. Before each check, the bench's own model of source flags, held words and latches is advanced only by the edges that have actually passed.

// File: rtl/iobus_pkg.sv
package iobus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_STALL = 2'd1,
        ST_WR_STALL = 2'd2,
        ST_RECOVER  = 2'd3
    } cyc_state_e;
endpackage

// File: rtl/iobus_sel_decode.sv
module iobus_sel_decode #(
    parameter int ADDR_W = 2,
    localparam int N_DEV = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              iom,
    input  logic              rd,
    input  logic              wr,
    output logic              req_rd,
    output logic              req_wr,
    output logic              any_strobe,
    output logic [N_DEV-1:0]  dev_hot
);
    // a cycle is an I/O access only with the qualifier high and exactly one strobe
    assign req_rd     = iom & rd & ~wr;
    assign req_wr     = iom & wr & ~rd;
    assign any_strobe = rd | wr;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dec
        assign dev_hot[g] = (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/iobus_cycle_fsm.sv
module iobus_cycle_fsm
    import iobus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_rd,
    input  logic req_wr,
    input  logic any_strobe,
    input  logic rd_avail,
    input  logic wr_avail,
    output logic wait_o,
    output logic rd_drive,
    output logic rd_done,
    output logic wr_done
);
    cyc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_rd)      state_d = rd_avail ? ST_RECOVER : ST_RD_STALL;
                else if (req_wr) state_d = wr_avail ? ST_RECOVER : ST_WR_STALL;
            end
            ST_RD_STALL: begin
                if (!req_rd)       state_d = ST_IDLE;
                else if (rd_avail) state_d = ST_RECOVER;
            end
            ST_WR_STALL: begin
                if (!req_wr)       state_d = ST_IDLE;
                else if (wr_avail) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (!any_strobe) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wait_o   = 1'b0;
        rd_drive = 1'b0;
        rd_done  = 1'b0;
        wr_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rd_drive = req_rd;
                rd_done  = req_rd & rd_avail;
                wr_done  = req_wr & wr_avail;
                wait_o   = (req_rd & ~rd_avail) | (req_wr & ~wr_avail);
            end
            ST_RD_STALL: begin
                rd_drive = req_rd;
                rd_done  = req_rd & rd_avail;
                wait_o   = req_rd & ~rd_avail;
            end
            ST_WR_STALL: begin
                wr_done  = req_wr & wr_avail;
                wait_o   = req_wr & ~wr_avail;
            end
            ST_RECOVER: begin
                wait_o   = 1'b0;
            end
            default: wait_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/iobus_src_bank.sv
module iobus_src_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    localparam int N_DEV = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_DEV-1:0]        load,
    input  logic [N_DEV*DATA_W-1:0] load_data,
    input  logic [N_DEV-1:0]        sel_hot,
    input  logic                    consume,
    input  logic                    drive,
    output logic                    avail_sel,
    output logic [DATA_W-1:0]       rdata
);
    logic [DATA_W-1:0] hold_q [N_DEV];
    logic [N_DEV-1:0]  full_q;
    logic [DATA_W-1:0] sel_word;

    for (genvar g = 0; g < N_DEV; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q[g] <= '0;
                full_q[g] <= 1'b0;
            end else if (load[g]) begin
                // a fresh load outranks a consuming read at the same edge
                hold_q[g] <= load_data[g*DATA_W +: DATA_W];
                full_q[g] <= 1'b1;
            end else if (consume && sel_hot[g]) begin
                full_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (sel_hot[i]) sel_word = sel_word | hold_q[i];
        end
    end

    assign avail_sel = |(full_q & sel_hot);
    assign rdata     = drive ? sel_word : '0;
endmodule

// File: rtl/iobus_dst_bank.sv
module iobus_dst_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    localparam int N_DEV = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [N_DEV-1:0]        sel_hot,
    input  logic                    commit,
    input  logic [N_DEV-1:0]        ready,
    output logic                    ready_sel,
    output logic [N_DEV-1:0]        strobe,
    output logic [N_DEV*DATA_W-1:0] q
);
    assign ready_sel = |(ready & sel_hot);
    assign strobe    = commit ? sel_hot : '0;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dst
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[g*DATA_W +: DATA_W] <= '0;
            else if (strobe[g]) q[g*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/iobus_port_ctrl.sv
module iobus_port_ctrl #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    localparam int N_DEV = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_iom,
    input  logic                    io_rd,
    input  logic                    io_wr,
    input  logic [DATA_W-1:0]       io_wdata,
    output logic [DATA_W-1:0]       io_rdata,
    output logic                    io_drive,
    output logic                    io_wait,
    input  logic [N_DEV-1:0]        src_load,
    input  logic [N_DEV*DATA_W-1:0] src_data,
    input  logic [N_DEV-1:0]        dst_ready,
    output logic [N_DEV-1:0]        dst_strobe,
    output logic [N_DEV*DATA_W-1:0] dst_q
);
    logic             req_rd, req_wr, any_strobe;
    logic [N_DEV-1:0] dev_hot;
    logic             rd_avail, wr_avail;
    logic             rd_done, wr_done;

    iobus_sel_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr       (io_addr),
        .iom        (io_iom),
        .rd         (io_rd),
        .wr         (io_wr),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .any_strobe (any_strobe),
        .dev_hot    (dev_hot)
    );

    iobus_cycle_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .any_strobe (any_strobe),
        .rd_avail   (rd_avail),
        .wr_avail   (wr_avail),
        .wait_o     (io_wait),
        .rd_drive   (io_drive),
        .rd_done    (rd_done),
        .wr_done    (wr_done)
    );

    iobus_src_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (src_load),
        .load_data (src_data),
        .sel_hot   (dev_hot),
        .consume   (rd_done),
        .drive     (io_drive),
        .avail_sel (rd_avail),
        .rdata     (io_rdata)
    );

    iobus_dst_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata     (io_wdata),
        .sel_hot   (dev_hot),
        .commit    (wr_done),
        .ready     (dst_ready),
        .ready_sel (wr_avail),
        .strobe    (dst_strobe),
        .q         (dst_q)
    );
endmodule

// File: rtl/iobus_port_ctrl_chk.sv
module iobus_port_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    localparam int N_DEV = 1 << ADDR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       io_addr,
    input logic                    io_iom,
    input logic                    io_rd,
    input logic                    io_wr,
    input logic [DATA_W-1:0]       io_wdata,
    input logic [DATA_W-1:0]       io_rdata,
    input logic                    io_drive,
    input logic                    io_wait,
    input logic [N_DEV-1:0]        src_load,
    input logic [N_DEV*DATA_W-1:0] src_data,
    input logic [N_DEV-1:0]        dst_ready,
    input logic [N_DEV-1:0]        dst_strobe,
    input logic [N_DEV*DATA_W-1:0] dst_q
);
    a_r3_mem_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_iom |-> (!io_drive && !io_wait && dst_strobe == '0));

    a_r4_both_strobes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_wr) |-> (!io_drive && !io_wait && dst_strobe == '0));

    a_r2_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_strobe));

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_strobe == '0) |=> $stable(dst_q));

    a_r5_wait_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        io_wait |-> (io_iom && (io_rd != io_wr)));

    a_r9_one_read_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (io_drive && !io_wait) |=> !io_drive);

    a_r9_one_write_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_strobe != '0) |=> (dst_strobe == '0));

    a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !io_drive |-> (io_rdata == '0));
endmodule

bind iobus_port_ctrl iobus_port_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_iobus_port_ctrl.sv
`timescale 1ns/100ps
module sim_iobus_port_ctrl;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic          io_iom = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
    logic [DW-1:0] io_wdata = '0;
    logic [DW-1:0] io_rdata;
    logic          io_drive, io_wait;
    logic [ND-1:0] src_load = '0;
    logic [ND*DW-1:0] src_data = '0;
    logic [ND-1:0] dst_ready = '0;
    logic [ND-1:0] dst_strobe;
    logic [ND*DW-1:0] dst_q;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    bit            m_full [ND];
    logic [DW-1:0] m_hold [ND];
    logic [DW-1:0] m_dst  [ND];

    always #2.5 clk = ~clk;

    iobus_port_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

    function automatic logic [ND*DW-1:0] exp_dst();
        logic [ND*DW-1:0] v;
        for (int i = 0; i < ND; i++) v[i*DW +: DW] = m_dst[i];
        return v;
    endfunction

    function automatic bit exp_rd_wait(input int a);
        return !m_full[a];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_load(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        src_load[a] = 1'b1;
        src_data[a*DW +: DW] = v;
        @(negedge clk);
        src_load = '0;
        m_full[a] = 1'b1;
        m_hold[a] = v;
    endtask

    task automatic do_read(input int a, input int stall, input logic [DW-1:0] lv,
                           input bit push_done, input logic [DW-1:0] nv);
        @(negedge clk);
        io_addr = AW'(a); io_iom = 1'b1; io_rd = 1'b1; io_wr = 1'b0;
        #1;
        chk(io_wait == exp_rd_wait(a), "R5 wait on read", 32'(io_wait), 32'(exp_rd_wait(a)));
        chk(io_drive == 1'b1, "R2 drive on read", 32'(io_drive), 1);
        if (!m_full[a]) begin
            for (int k = 0; k < stall; k++) begin
                @(negedge clk); #1;
                chk(io_wait == 1'b1, "R5 stall holds", 32'(io_wait), 1);
            end
            src_load[a] = 1'b1;
            src_data[a*DW +: DW] = lv;
            @(negedge clk);
            src_load = '0;
            m_full[a] = 1'b1; m_hold[a] = lv;
            #1;
            chk(io_wait == 1'b0, "R5 wait released after load", 32'(io_wait), 0);
        end
        chk(io_rdata == m_hold[a], "R2 read data", 32'(io_rdata), 32'(m_hold[a]));
        if (push_done) begin
            src_load[a] = 1'b1;
            src_data[a*DW +: DW] = nv;
        end
        @(negedge clk);
        src_load = '0;
        if (push_done) m_hold[a] = nv;
        else           m_full[a] = 1'b0;
        #1;
        chk(io_drive == 1'b0, "R9 no drive in recover", 32'(io_drive), 0);
        chk(io_rdata == '0, "R11 rdata zero", 32'(io_rdata), 0);
        chk(io_wait == 1'b0, "R9 no wait in recover", 32'(io_wait), 0);
        @(negedge clk);
        io_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input int stall, input logic [DW-1:0] d);
        @(negedge clk);
        dst_ready[a] = (stall == 0);
        io_addr = AW'(a); io_iom = 1'b1; io_wr = 1'b1; io_rd = 1'b0; io_wdata = d;
        #1;
        chk(io_wait == (stall != 0), "R6 wait on write", 32'(io_wait), 32'(stall != 0));
        for (int k = 0; k < stall; k++) begin
            @(negedge clk); #1;
            chk(io_wait == 1'b1, "R6 stall holds", 32'(io_wait), 1);
            chk(dst_q == exp_dst(), "R6 latch unchanged in stall", dst_q, exp_dst());
        end
        if (stall != 0) begin
            dst_ready[a] = 1'b1;
            #1;
            chk(io_wait == 1'b0, "R6 wait released", 32'(io_wait), 0);
        end
        chk(dst_strobe == ND'(1 << a), "R7 strobe", 32'(dst_strobe), 32'(1 << a));
        @(negedge clk);
        m_dst[a] = d;
        #1;
        chk(dst_q == exp_dst(), "R7 latch update", dst_q, exp_dst());
        chk(dst_strobe == '0, "R9 no strobe in recover", 32'(dst_strobe), 0);
        io_wdata = ~d;
        @(negedge clk); #1;
        chk(dst_q == exp_dst(), "R9 held strobe no rewrite", dst_q, exp_dst());
        io_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ignored(input int a, input int mode);
        @(negedge clk);
        dst_ready[a] = 1'b0;
        io_addr = AW'(a); io_wdata = 8'hC3;
        io_iom = (mode == 2);
        io_rd  = (mode != 1);
        io_wr  = (mode != 0);
        #1;
        chk(!io_wait && !io_drive && io_rdata == '0 && dst_strobe == '0,
            (mode == 2) ? "R4 both strobes ignored" : "R3 memory cycle ignored",
            {io_wait, io_drive, dst_strobe, io_rdata}, 0);
        @(negedge clk); #1;
        chk(dst_q == exp_dst(), (mode == 2) ? "R4 latch unchanged" : "R3 latch unchanged", dst_q, exp_dst());
        io_rd = 1'b0; io_wr = 1'b0; io_iom = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_abandon(input int a, input bit is_wr);
        @(negedge clk);
        io_addr = AW'(a); io_iom = 1'b1; io_wdata = 8'h5A;
        if (is_wr) begin dst_ready[a] = 1'b0; io_wr = 1'b1; end
        else io_rd = 1'b1;
        #1;
        chk(io_wait == 1'b1, "R10 stall before withdraw", 32'(io_wait), 1);
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        #1;
        chk(io_wait == 1'b0 && io_drive == 1'b0, "R10 withdraw clears wait",
            {io_wait, io_drive}, 0);
        @(negedge clk); #1;
        chk(dst_q == exp_dst(), "R10 no latch change", dst_q, exp_dst());
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h51C0_7E11));
        for (int i = 0; i < ND; i++) begin m_full[i] = 0; m_hold[i] = '0; m_dst[i] = '0; end
        repeat (3) @(negedge clk);
        #1;
        chk(!io_wait && !io_drive && io_rdata == '0 && dst_strobe == '0 && dst_q == '0,
            "R1 reset state", {io_wait, io_drive, dst_strobe, io_rdata}, 0);
        rst_n = 1'b1;
        // R1: empty after reset, and R10: withdrawing leaves it empty
        do_abandon(2, 1'b0);
        do_read(2, 2, 8'h3C, 1'b0, 8'h00);
        // R8: consumed source stalls on the next read
        do_read(2, 1, 8'h81, 1'b0, 8'h00);
        // R8: load coinciding with consume keeps data
        do_load(1, 8'h11);
        do_read(1, 0, 8'h00, 1'b1, 8'hEE);
        do_read(1, 0, 8'h00, 1'b0, 8'h00);
        // R2 and R7 per destination, R6 stalls
        for (int i = 0; i < ND; i++) do_write(i, i, 8'(8'h20 + i));
        do_abandon(3, 1'b1);
        // R3, R4 with a full source kept
        do_load(0, 8'h77);
        do_ignored(0, 0);
        do_ignored(0, 1);
        do_ignored(0, 2);
        do_read(0, 0, 8'h00, 1'b0, 8'h00);
        for (int it = 0; it < 300; it++) begin
            int a;
            int op;
            a  = int'($urandom % ND);
            op = int'($urandom % 7);
            dst_ready = ND'($urandom);
            case (op)
                0, 1: do_read(a, int'($urandom % 4), 8'($urandom), 1'($urandom), 8'($urandom));
                2, 3: do_write(a, int'($urandom % 4), 8'($urandom));
                4:    do_load(a, 8'($urandom));
                5:    do_ignored(a, int'($urandom % 3));
                default: begin
                    if (!m_full[a]) do_abandon(a, 1'b0);
                    else            do_abandon(a, 1'b1);
                end
            endcase
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule